// File: doc/BRIEF.md
# Buffered I2C Write Receiver

This block is the target side of an I2C bus that takes in a controller's write burst and places it in a small local byte buffer, so software does not have to service the bus after every byte. It watches SCL and SDA through synchronisers. It matches a programmable 7-bit own address and acknowledges a write request by pulling SDA low. The address byte it accepted is kept in a single-byte data register, where software can read it.

Once the address is acknowledged, software sets a receive offset and a size-minus-one, then arms the buffer through a command bit. Incoming bytes are acknowledged and written to consecutive buffer slots, starting at the offset and wrapping round the buffer. When the armed size is reached, the block flags receive-complete and holds SCL low until software arms it again. A STOP that ends a partly filled burst flags stop and receive-complete together. The byte-count field then tells software how many slots to drain through the buffer read port. Read requests and general call are not served.

Top module: `i2c_buf_target`

## Requirements
- R1: After reset, scl_oe_o and sda_oe_o are 0, the status register (index 3) reads 0 and the count field reads 0.
- R2: An address byte equal to {own address, 0} is acknowledged. The own address is held in register 0 bits 6:0. The byte is latched into the data register (index 4, bits 7:0), and status bit 0 (address hit) is set.
- R3: An address byte that does not match the own address is not acknowledged, sets no status bit, and its STOP sets no stop flag.
- R4: A matching address byte with bit 0 set (read request) is latched into the data register and sets status bit 0, but is not acknowledged.
- R5: Writing 1 to bit 0 of the command register (index 1) arms reception and clears the count field. The count field is bits 28:24 of register 2. The arm uses the offset in register 2 bits 3:0 and the size-minus-one in register 2 bits 11:8.
- R6: Every data byte received while armed is acknowledged. It is stored at slot (offset + count) modulo DEPTH, which the buffer read port can read, and the count is incremented.
- R7: When the count reaches size-minus-one plus 1, status bit 1 (receive complete) is set and the block disarms.
- R8: When an acknowledge bit ends and the block is not armed, scl_oe_o holds SCL low until software arms the block. SCL is released within a few cycles of the arm.
- R9: A STOP after an acknowledged write sets status bit 2. If bytes have been stored since the last arm or the last completion, it also sets status bit 1. The count is kept.
- R10: Any START, including a repeated START, clears the count, disarms, and returns the receiver to the address phase.
- R11: Writing status with a bit set to 1 clears that bit. A 0 in a bit leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low (clock stretch) |
| sda_oe_o | output | 1 | Pull SDA low (acknowledge) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| buf_raddr_i | input | AW | Buffer read slot |
| buf_rdata_o | output | 8 | Buffer read data (combinational) |

## Verification
The bench builds the block with its defaults: DEPTH=16 and two synchroniser stages. A 16-slot buffer with a 4-bit offset lets a three-byte burst starting at offset 14 wrap round to slot 0. The same configuration reaches the two extremes of the size field: a one-byte buffer with size-minus-one 0, which completes on its first byte, and a burst that fills the full armed size. With these defaults the bench also forces clock stretching. It does this both after the address acknowledge, when the block has not been armed yet, and in the middle of a burst, when the buffer has filled, so the re-arm path is exercised.

// File: rtl/i2c_buf_pkg.sv
package i2c_buf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_DATA, ST_DACK, ST_HOLD
  } rx_state_e;

  localparam logic [2:0] REG_OWN  = 3'd0;
  localparam logic [2:0] REG_CMD  = 3'd1;
  localparam logic [2:0] REG_BUF  = 3'd2;
  localparam logic [2:0] REG_STS  = 3'd3;
  localparam logic [2:0] REG_DATA = 3'd4;

  localparam int STS_ADDR = 0;
  localparam int STS_DONE = 1;
  localparam int STS_STOP = 2;

  localparam int BUF_SIZE_LSB = 8;
  localparam int BUF_CNT_LSB  = 24;
endpackage

// File: rtl/i2c_buf_sync.sv
module i2c_buf_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o,
  output logic [N-1:0] q_prev_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '1;
      else         sh_q <= {sh_q[STAGES-1:0], d_i[g]};
    end
    assign q_o[g]      = sh_q[STAGES-1];
    assign q_prev_o[g] = sh_q[STAGES];
  end
endmodule

// File: rtl/i2c_buf_engine.sv
module i2c_buf_engine
  import i2c_buf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       scl_prev_i,
  input  logic       sda_i,
  input  logic       sda_prev_i,
  input  logic [6:0] own_addr_i,
  input  logic       armed_i,
  output logic       sda_oe_o,
  output logic       scl_oe_o,
  output logic       start_o,
  output logic       stop_o,
  output logic       addr_o,
  output logic       byte_o,
  output logic [7:0] byte_q_o
);
  rx_state_e  state_q;
  logic [7:0] sh_q;
  logic [3:0] bit_q;
  logic       sel_q;

  logic scl_rise, scl_fall, start_det, stop_det;
  assign scl_rise  = scl_i & ~scl_prev_i;
  assign scl_fall  = ~scl_i & scl_prev_i;
  assign start_det = scl_i & scl_prev_i & sda_prev_i & ~sda_i;
  assign stop_det  = scl_i & scl_prev_i & ~sda_prev_i & sda_i;
  assign byte_q_o  = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      sh_q     <= '0;
      bit_q    <= '0;
      sel_q    <= 1'b0;
      sda_oe_o <= 1'b0;
      scl_oe_o <= 1'b0;
      start_o  <= 1'b0;
      stop_o   <= 1'b0;
      addr_o   <= 1'b0;
      byte_o   <= 1'b0;
    end else begin
      start_o <= 1'b0;
      stop_o  <= 1'b0;
      addr_o  <= 1'b0;
      byte_o  <= 1'b0;
      if (start_det) begin
        state_q  <= ST_ADDR;
        bit_q    <= '0;
        sel_q    <= 1'b0;
        sda_oe_o <= 1'b0;
        scl_oe_o <= 1'b0;
        start_o  <= 1'b1;
      end else if (stop_det) begin
        state_q  <= ST_IDLE;
        sda_oe_o <= 1'b0;
        scl_oe_o <= 1'b0;
        stop_o   <= sel_q;
        sel_q    <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR, ST_DATA: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[6:0], sda_i};
              bit_q <= bit_q + 4'd1;
            end else if (scl_fall && bit_q == 4'd8) begin
              if (state_q == ST_DATA) begin
                byte_o   <= 1'b1;
                sda_oe_o <= 1'b1;
                state_q  <= ST_DACK;
              end else if (sh_q[7:1] == own_addr_i) begin
                addr_o <= 1'b1;
                if (!sh_q[0]) begin
                  sda_oe_o <= 1'b1;
                  sel_q    <= 1'b1;
                  state_q  <= ST_AACK;
                end else begin
                  state_q <= ST_IDLE;  // read requests are not served
                end
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_AACK, ST_DACK: begin
            if (scl_fall) begin
              sda_oe_o <= 1'b0;
              bit_q    <= '0;
              if (armed_i) begin
                state_q <= ST_DATA;
              end else begin
                state_q  <= ST_HOLD;
                scl_oe_o <= 1'b1;
              end
            end
          end
          ST_HOLD: begin
            if (armed_i) begin
              scl_oe_o <= 1'b0;
              state_q  <= ST_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_buf_store.sv
module i2c_buf_store #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/i2c_buf_target.sv
module i2c_buf_target
  import i2c_buf_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe_o,
  output logic          sda_oe_o,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic [AW-1:0] buf_raddr_i,
  output logic [7:0]    buf_rdata_o
);
  logic [1:0] line_s, line_p;
  logic       start_evt, stop_evt, addr_evt, byte_evt;
  logic [7:0] rx_byte;

  logic [6:0]    own_q;
  logic [AW-1:0] off_q, size_q;
  logic [AW:0]   cnt_q;
  logic          armed_q, pend_q;
  logic [2:0]    sts_q;
  logic [7:0]    data_q;

  i2c_buf_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .d_i      ({sda_i, scl_i}),
    .q_o      (line_s),
    .q_prev_o (line_p)
  );

  i2c_buf_engine u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (line_s[0]),
    .scl_prev_i (line_p[0]),
    .sda_i      (line_s[1]),
    .sda_prev_i (line_p[1]),
    .own_addr_i (own_q),
    .armed_i    (armed_q),
    .sda_oe_o   (sda_oe_o),
    .scl_oe_o   (scl_oe_o),
    .start_o    (start_evt),
    .stop_o     (stop_evt),
    .addr_o     (addr_evt),
    .byte_o     (byte_evt),
    .byte_q_o   (rx_byte)
  );

  logic          arm_wr, store, full;
  logic [AW-1:0] waddr;
  assign arm_wr = reg_we_i && reg_addr_i == REG_CMD && reg_wdata_i[0];
  assign store  = byte_evt && armed_q && !start_evt && !arm_wr;
  assign full   = store && cnt_q == {1'b0, size_q};
  assign waddr  = off_q + cnt_q[AW-1:0];

  i2c_buf_store #(.DEPTH(DEPTH), .W(8)) u_store (
    .clk_i   (clk_i),
    .we_i    (store),
    .waddr_i (waddr),
    .wdata_i (rx_byte),
    .raddr_i (buf_raddr_i),
    .rdata_o (buf_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q   <= '0;
      off_q   <= '0;
      size_q  <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
      sts_q   <= '0;
      data_q  <= '0;
    end else begin
      if (reg_we_i && reg_addr_i == REG_OWN) own_q <= reg_wdata_i[6:0];
      if (reg_we_i && reg_addr_i == REG_BUF) begin
        off_q  <= reg_wdata_i[AW-1:0];
        size_q <= reg_wdata_i[BUF_SIZE_LSB +: AW];
      end
      if (addr_evt) data_q <= rx_byte;

      if (start_evt) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
        pend_q  <= 1'b0;
      end else if (arm_wr) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
        pend_q  <= 1'b0;
      end else if (store) begin
        cnt_q  <= cnt_q + 1'b1;
        pend_q <= !full;
        if (full) armed_q <= 1'b0;
      end else if (stop_evt) begin
        armed_q <= 1'b0;
        pend_q  <= 1'b0;
      end

      sts_q <= (sts_q & ~((reg_we_i && reg_addr_i == REG_STS) ? reg_wdata_i[2:0] : 3'b000))
             | {stop_evt,
                full | (stop_evt & pend_q),
                addr_evt};
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      REG_OWN:  reg_rdata_o[6:0] = own_q;
      REG_BUF: begin
        reg_rdata_o[AW-1:0]               = off_q;
        reg_rdata_o[BUF_SIZE_LSB +: AW]   = size_q;
        reg_rdata_o[BUF_CNT_LSB +: AW+1]  = cnt_q;
      end
      REG_STS:  reg_rdata_o[2:0] = sts_q;
      REG_DATA: reg_rdata_o[7:0] = data_q;
      default: ;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^{reg_wdata_i[31:BUF_SIZE_LSB+AW], reg_wdata_i[BUF_SIZE_LSB-1:AW], reg_wdata_i[7]};
endmodule

// File: rtl/i2c_buf_target_chk.sv
module i2c_buf_target_chk #(
  parameter int AW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_oe_o,
  input logic          armed_q,
  input logic [AW:0]   cnt_q,
  input logic [AW-1:0] size_q,
  input logic          byte_evt,
  input logic          start_evt,
  input logic          stop_evt,
  input logic [2:0]    sts_q,
  input logic          reg_we_i,
  input logic [2:0]    reg_addr_i,
  input logic [31:0]   reg_wdata_i
);
  logic arm_req;
  assign arm_req = reg_we_i && reg_addr_i == 3'd1 && reg_wdata_i[0];

  assert_arm_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_req && !start_evt) |=> (cnt_q == '0 && armed_q));

  assert_count_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (cnt_q <= {1'b0, size_q}));

  assert_full_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_evt && armed_q && cnt_q == {1'b0, size_q} && !start_evt && !arm_req)
      |=> (sts_q[1] && !armed_q));

  assert_stretch_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_oe_o && armed_q) |=> !scl_oe_o);

  assert_stop_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_evt |=> sts_q[2]);

  assert_start_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_evt |=> (cnt_q == '0 && !armed_q));
endmodule

bind i2c_buf_target i2c_buf_target_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_oe_o    (scl_oe_o),
  .armed_q     (armed_q),
  .cnt_q       (cnt_q),
  .size_q      (size_q),
  .byte_evt    (byte_evt),
  .start_evt   (start_evt),
  .stop_evt    (stop_evt),
  .sts_q       (sts_q),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i)
);

// File: tb/sim_i2c_buf_target.sv
`timescale 1ns/1ps
module sim_i2c_buf_target;
  localparam int T = 20;  // half bit, in clocks
  localparam logic [7:0] WR_ADDR = 8'h74;
  localparam logic [7:0] RD_ADDR = 8'h75;
  // {seed[23:16], n[12:8], offset[7:4], size_m1[3:0]}
  localparam logic [23:0] VEC [4] = '{24'hA0_03_0F, 24'h11_08_57, 24'h5C_03_E3, 24'hF0_01_90};

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic scl_oe, sda_oe, scl_line, sda_line;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [3:0] buf_raddr = '0;
  logic [7:0] buf_rdata;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;
  assign scl_line = scl_drv & ~scl_oe;
  assign sda_line = sda_drv & ~sda_oe;

  i2c_buf_target u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .buf_raddr_i(buf_raddr),
    .buf_rdata_o(buf_rdata)
  );

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual hung expected done");
    finish_run();
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic buf_rd(input int idx, output logic [7:0] v);
    @(negedge clk);
    buf_raddr = idx[3:0];
    #1 v = buf_rdata;
  endtask

  task automatic scl_up();
    scl_drv = 1'b1;
    while (!scl_line) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    sda_drv = b; tick(T/2);
    scl_up(); tick(T);
    scl_drv = 1'b0; tick(T/2);
  endtask

  task automatic byte_out(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    sda_drv = 1'b1; tick(T/2);
    scl_up(); tick(T/2);
    ack = !sda_line;
    tick(T/2);
    scl_drv = 1'b0; tick(T/2);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; tick(T/2);
    scl_up(); tick(T);
    sda_drv = 1'b0; tick(T);
    scl_drv = 1'b0; tick(T/2);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; tick(T/2);
    scl_up(); tick(T);
    sda_drv = 1'b1; tick(T);
  endtask

  logic [31:0] v;
  logic [7:0]  bv;
  bit          ack;
  int          sm1, off, n;
  logic [7:0]  seed;

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(3);
    // R1 reset state
    chk("R1 scl_oe", int'(scl_oe), 0);
    chk("R1 sda_oe", int'(sda_oe), 0);
    rd(3'd3, v); chk("R1 status", int'(v), 0);
    rd(3'd2, v); chk("R1 count", int'(v[28:24]), 0);

    wr(3'd0, 32'h3A);

    // table-driven write bursts
    for (int k = 0; k < 4; k++) begin
      sm1  = int'(VEC[k][3:0]);
      off  = int'(VEC[k][7:4]);
      n    = int'(VEC[k][12:8]);
      seed = VEC[k][23:16];
      bus_start();
      byte_out(WR_ADDR, ack); chk("R2 addr ack", int'(ack), 1);
      rd(3'd4, v); chk("R2 data reg", int'(v[7:0]), int'(WR_ADDR));
      rd(3'd3, v); chk("R2 addr hit", int'(v[0]), 1);
      wr(3'd3, 32'h7);
      wr(3'd2, (sm1 << 8) | off);
      wr(3'd1, 32'h1);
      for (int i = 0; i < n; i++) begin
        byte_out(seed + 8'(i * 3), ack); chk("R6 data ack", int'(ack), 1);
      end
      if (n == sm1 + 1) begin
        tick(20);
        chk("R8 stretch when full", int'(scl_oe), 1);
        rd(3'd2, v); chk("R7 count at full", int'(v[28:24]), n);
        rd(3'd3, v); chk("R7 done at full", int'(v[2:0]), 3'b010);
        wr(3'd3, 32'h7);
        wr(3'd1, 32'h1);
        tick(4);
        chk("R8 release on arm", int'(scl_oe), 0);
        bus_stop();
        rd(3'd3, v); chk("R9 stop no pending", int'(v[2:0]), 3'b100);
      end else begin
        bus_stop();
        rd(3'd3, v); chk("R9 stop with pending", int'(v[2:0]), 3'b110);
        rd(3'd2, v); chk("R9 count kept", int'(v[28:24]), n);
      end
      for (int i = 0; i < n; i++) begin
        buf_rd((off + i) % 16, bv); chk("R6 buffer slot", int'(bv), int'(seed + 8'(i * 3)));
      end
      wr(3'd3, 32'h7);
    end

    // R3 address mismatch
    bus_start();
    byte_out(8'h20, ack); chk("R3 no ack", int'(ack), 0);
    bus_stop();
    rd(3'd3, v); chk("R3 no status", int'(v[2:0]), 0);

    // R4 read request
    bus_start();
    byte_out(RD_ADDR, ack); chk("R4 read nack", int'(ack), 0);
    rd(3'd3, v); chk("R4 addr hit", int'(v[2:0]), 3'b001);
    rd(3'd4, v); chk("R4 data reg", int'(v[7:0]), int'(RD_ADDR));
    bus_stop();
    rd(3'd3, v); chk("R4 no stop flag", int'(v[2:0]), 3'b001);
    wr(3'd3, 32'h7);

    // R8 stretch before arming, R7 full mid-burst, R11 W1C, R5 re-arm
    bus_start();
    byte_out(WR_ADDR, ack); chk("R2 addr ack", int'(ack), 1);
    tick(20);
    chk("R8 stretch unarmed", int'(scl_oe), 1);
    wr(3'd2, 32'h0103);
    wr(3'd1, 32'h1);
    tick(4);
    chk("R8 release after arm", int'(scl_oe), 0);
    byte_out(8'hC1, ack); chk("R6 ack C1", int'(ack), 1);
    byte_out(8'hC2, ack); chk("R6 ack C2", int'(ack), 1);
    tick(20);
    chk("R8 stretch at full", int'(scl_oe), 1);
    rd(3'd2, v); chk("R7 count two", int'(v[28:24]), 2);
    rd(3'd3, v); chk("R7 done set", int'(v[2:0]), 3'b011);
    buf_rd(3, bv); chk("R6 slot 3", int'(bv), 8'hC1);
    buf_rd(4, bv); chk("R6 slot 4", int'(bv), 8'hC2);
    wr(3'd3, 32'h2);
    rd(3'd3, v); chk("R11 clear only done", int'(v[2:0]), 3'b001);
    wr(3'd3, 32'h1);
    rd(3'd3, v); chk("R11 clear addr hit", int'(v[2:0]), 0);
    wr(3'd1, 32'h1);
    rd(3'd2, v); chk("R5 arm clears count", int'(v[28:24]), 0);
    chk("R5 offset field", int'(v[3:0]), 3);
    chk("R5 size field", int'(v[11:8]), 1);
    byte_out(8'hC3, ack); chk("R6 ack C3", int'(ack), 1);
    bus_stop();
    rd(3'd3, v); chk("R9 pending at stop", int'(v[2:0]), 3'b110);
    rd(3'd2, v); chk("R9 count one", int'(v[28:24]), 1);
    buf_rd(3, bv); chk("R6 slot 3 reused", int'(bv), 8'hC3);
    wr(3'd3, 32'h7);

    // R10 repeated START
    wr(3'd2, 32'h0F00);
    bus_start();
    byte_out(WR_ADDR, ack);
    wr(3'd1, 32'h1);
    byte_out(8'hD5, ack);
    byte_out(8'hD6, ack);
    rd(3'd2, v); chk("R10 count before", int'(v[28:24]), 2);
    bus_start();
    rd(3'd2, v); chk("R10 count cleared", int'(v[28:24]), 0);
    byte_out(WR_ADDR, ack); chk("R10 address phase", int'(ack), 1);
    wr(3'd1, 32'h1);
    byte_out(8'hD0, ack);
    bus_stop();
    rd(3'd2, v); chk("R10 count after", int'(v[28:24]), 1);
    buf_rd(0, bv); chk("R10 slot 0", int'(bv), 8'hD0);

    finish_run();
  end
endmodule